// File: doc/BRIEF.md
# Three-Port Byte Parity Guard

This block sits at the edges of a token-ring MAC core. It attaches odd parity to every byte the core sends toward the line-side transceiver. It checks the parity of bytes that arrive on three paths: the line-side receive path, the host-side transmit path and the register bus. Each check has its own enable. Each path reacts to a parity error in its own way.

- **Line-side receive path.** The error counts as a code violation. If it lands inside a token or frame, that unit is stripped, a format error pulse is raised and a lost counter advances.
- **Host-side transmit path.** While the core acknowledges transmission, the error aborts the frame in flight. A Void-frame request follows so that every station's valid-transmission timer restarts.
- **Register bus.** The error cancels the write and raises two flags: one for the parity fault and one saying the write was not performed.

On the register bus, parity is removed from written data before it reaches the registers and generated freshly on read data, so no register stores parity. All faults are recorded in a sticky status vector that software clears by strobing ones into the bit positions.

Top module: `xpg_parity_guard`

## Requirements
- R1: After reset, every status bit, the lost counter and every pulse output (`prx_cv`, `prx_strip`, `prx_fmt_err`, `mtx_abort`, `void_req`, `reg_wr`, `ptx_vld_q`) are 0.
- R2: One cycle after `ptx_data`/`ptx_vld` are sampled, `ptx_data_q` and `ptx_vld_q` repeat them unchanged, and `ptx_par_q` is set so that the nine bits together hold an odd number of ones.
- R3: A received byte whose nine bits hold an even number of ones, sampled with `prx_vld` and `en_phy_par` high, pulses `prx_cv` for one cycle on the next cycle and sets status bit 0. With `en_phy_par` low, the same byte has no effect.
- R4: If such a line-side error occurs while `prx_in_frame` is high, `prx_strip` and `prx_fmt_err` pulse on the next cycle and `lost_cnt` increments by one, holding at 255 once reached. Outside a frame there is no strip, no format error and no count.
- R5: A host-side byte with even parity, sampled with `mtx_vld`, `mtx_ack` and `en_mac_par` high, pulses `mtx_abort` on the next cycle and sets status bit 1. Without `mtx_ack` or without the enable, it has no effect.
- R6: `void_req` pulses for exactly one cycle, in the cycle after each `mtx_abort` pulse.
- R7: A register write (`cb_wr`) whose data and parity hold an even number of ones while `en_cb_par` is high is not forwarded (`reg_wr` stays 0 on the next cycle) and sets status bits 2 (parity fault) and 3 (write cancelled). A write with correct parity is forwarded on the next cycle as `reg_wr` with `reg_wdata` equal to the eight data bits.
- R8: With `en_cb_par` low, every register write is forwarded on the next cycle whatever its parity bit, and status bits 2 and 3 are not set.
- R9: `cb_rpar` is, in the same cycle, the odd-parity bit of `reg_rdata`.
- R10: Status bits stay set until a cycle in which `stat_clr` has a one at their position. A bit that is set and cleared in the same cycle stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_phy_par | input | 1 | Enable line-side receive parity check |
| en_mac_par | input | 1 | Enable host-side transmit parity check |
| en_cb_par | input | 1 | Enable register-bus write parity check |
| ptx_data | input | 8 | Byte headed to the transceiver |
| ptx_vld | input | 1 | Byte valid toward the transceiver |
| ptx_data_q | output | 8 | Registered transmit byte |
| ptx_par_q | output | 1 | Odd parity of the registered byte |
| ptx_vld_q | output | 1 | Registered valid |
| prx_data | input | 8 | Received byte |
| prx_par | input | 1 | Parity bit of received byte |
| prx_vld | input | 1 | Received byte valid |
| prx_in_frame | input | 1 | Token or frame reception in progress |
| prx_cv | output | 1 | Code-violation pulse from a parity error |
| prx_strip | output | 1 | Strip-current-unit pulse |
| prx_fmt_err | output | 1 | Format error pulse |
| lost_cnt | output | 8 | Saturating lost count |
| mtx_data | input | 8 | Host-side transmit byte |
| mtx_par | input | 1 | Parity bit of host-side byte |
| mtx_vld | input | 1 | Host-side byte valid |
| mtx_ack | input | 1 | Transmission acknowledged by the core |
| mtx_abort | output | 1 | Transmit abort pulse |
| void_req | output | 1 | Request to send a Void frame |
| cb_wr | input | 1 | Register write strobe |
| cb_wdata | input | 8 | Register write data |
| cb_wpar | input | 1 | Parity of write data |
| reg_wr | output | 1 | Forwarded write strobe |
| reg_wdata | output | 8 | Forwarded write data, parity removed |
| reg_rdata | input | 8 | Register read data |
| cb_rpar | output | 1 | Generated parity of read data |
| stat_clr | input | 4 | Write-one-to-clear strobe for status bits |
| status | output | 4 | Sticky status: 0 line, 1 host, 2 bus parity, 3 write cancelled |

## Verification
The assertions check on every cycle these per-cycle relations:
- outgoing bytes always carry odd parity;
- the lost count never moves by more than one and stays pinned once full;
- a strip only happens inside a frame;
- nothing aborts without acknowledge, and every abort is followed by a Void request;
- a faulty enabled write is never forwarded;
- status bits stay set unless cleared.

Only the bench's scenarios can show the rest:
- each enable really gates its check;
- the counter reaches exactly 255 after a long error burst;
- set-over-clear priority holds;
- the forwarded data and generated read parity match values worked out independently.

// File: rtl/xpg_pkg.sv
package xpg_pkg;
   localparam int ST_W        = 4;
   localparam int ST_PHY_PE   = 0;
   localparam int ST_MAC_PE   = 1;
   localparam int ST_CB_PE    = 2;
   localparam int ST_CB_CANCL = 3;
endpackage

// File: rtl/xpg_phy_rx.sv
module xpg_phy_rx #(
   parameter int DW    = 8,
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DW-1:0]    data,
   input  logic             par,
   input  logic             vld,
   input  logic             in_frame,
   output logic             err,
   output logic             cv,
   output logic             strip,
   output logic             fmt_err,
   output logic [CNT_W-1:0] lost
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic hit_frame;

   assign err       = en & vld & ~(^{data, par});
   assign hit_frame = err & in_frame;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cv      <= 1'b0;
         strip   <= 1'b0;
         fmt_err <= 1'b0;
         lost    <= '0;
      end else begin
         cv      <= err;
         strip   <= hit_frame;
         fmt_err <= hit_frame;
         if (hit_frame && lost != CNT_MAX)
            lost <= lost + 1'b1;
      end
   end

   a_r4_lost_sat: assert property (@(posedge clk) disable iff (!rst_n)
      (lost == CNT_MAX) |=> (lost == CNT_MAX));
   a_r4_lost_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (lost == $past(lost) || lost == $past(lost) + 1'b1));
   a_r4_strip_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      strip |-> $past(in_frame));
endmodule

// File: rtl/xpg_mac_tx.sv
module xpg_mac_tx #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [DW-1:0] data,
   input  logic          par,
   input  logic          vld,
   input  logic          ack,
   output logic          err,
   output logic          abort,
   output logic          void_req
);
   assign err = en & vld & ack & ~(^{data, par});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         abort    <= 1'b0;
         void_req <= 1'b0;
      end else begin
         abort    <= err;
         void_req <= abort;
      end
   end

   a_r5_no_abort_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> !abort);
   a_r6_void_follows_abort: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> void_req);
endmodule

// File: rtl/xpg_cb_port.sv
module xpg_cb_port #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          wpar,
   output logic          err,
   output logic          reg_wr,
   output logic [DW-1:0] reg_wdata,
   input  logic [DW-1:0] rdata,
   output logic          rpar
);
   assign err  = en & wr & ~(^{wdata, wpar});
   assign rpar = ~(^rdata);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_wr    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_wr    <= wr & ~err;
         reg_wdata <= wdata;
      end
   end

   a_r7_cancel_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !reg_wr);
   a_r8_plain_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !en) |=> reg_wr);
endmodule

// File: rtl/xpg_status.sv
module xpg_status #(
   parameter int W        = 4,
   parameter bit SET_PRIO = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set,
   input  logic [W-1:0] clr,
   output logic [W-1:0] q
);
   logic [W-1:0] nxt;

   generate
      if (SET_PRIO) begin : g_set_wins
         assign nxt = (q & ~clr) | set;
      end else begin : g_clr_wins
         assign nxt = (q | set) & ~clr;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ((q & ~clr) != '0) |=> ((q & $past(q & ~clr)) == $past(q & ~clr)));
endmodule

// File: rtl/xpg_parity_guard.sv
module xpg_parity_guard #(
   parameter int DW       = 8,
   parameter int CNT_W    = 8,
   parameter bit SET_PRIO = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en_phy_par,
   input  logic                   en_mac_par,
   input  logic                   en_cb_par,
   input  logic [DW-1:0]          ptx_data,
   input  logic                   ptx_vld,
   output logic [DW-1:0]          ptx_data_q,
   output logic                   ptx_par_q,
   output logic                   ptx_vld_q,
   input  logic [DW-1:0]          prx_data,
   input  logic                   prx_par,
   input  logic                   prx_vld,
   input  logic                   prx_in_frame,
   output logic                   prx_cv,
   output logic                   prx_strip,
   output logic                   prx_fmt_err,
   output logic [CNT_W-1:0]       lost_cnt,
   input  logic [DW-1:0]          mtx_data,
   input  logic                   mtx_par,
   input  logic                   mtx_vld,
   input  logic                   mtx_ack,
   output logic                   mtx_abort,
   output logic                   void_req,
   input  logic                   cb_wr,
   input  logic [DW-1:0]          cb_wdata,
   input  logic                   cb_wpar,
   output logic                   reg_wr,
   output logic [DW-1:0]          reg_wdata,
   input  logic [DW-1:0]          reg_rdata,
   output logic                   cb_rpar,
   input  logic [xpg_pkg::ST_W-1:0] stat_clr,
   output logic [xpg_pkg::ST_W-1:0] status
);
   import xpg_pkg::*;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("xpg_parity_guard: DW must be at least 1");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("xpg_parity_guard: CNT_W must be at least 1");
      end
   endgenerate

   logic             phy_err, mac_err, cb_err;
   logic [ST_W-1:0]  st_set;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptx_data_q <= '0;
         ptx_par_q  <= 1'b1;
         ptx_vld_q  <= 1'b0;
      end else begin
         ptx_data_q <= ptx_data;
         ptx_par_q  <= ~(^ptx_data);
         ptx_vld_q  <= ptx_vld;
      end
   end

   xpg_phy_rx #(.DW(DW), .CNT_W(CNT_W)) u_phy_rx (
      .clk(clk), .rst_n(rst_n), .en(en_phy_par), .data(prx_data), .par(prx_par),
      .vld(prx_vld), .in_frame(prx_in_frame), .err(phy_err), .cv(prx_cv),
      .strip(prx_strip), .fmt_err(prx_fmt_err), .lost(lost_cnt));

   xpg_mac_tx #(.DW(DW)) u_mac_tx (
      .clk(clk), .rst_n(rst_n), .en(en_mac_par), .data(mtx_data), .par(mtx_par),
      .vld(mtx_vld), .ack(mtx_ack), .err(mac_err), .abort(mtx_abort),
      .void_req(void_req));

   xpg_cb_port #(.DW(DW)) u_cb_port (
      .clk(clk), .rst_n(rst_n), .en(en_cb_par), .wr(cb_wr), .wdata(cb_wdata),
      .wpar(cb_wpar), .err(cb_err), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .rdata(reg_rdata), .rpar(cb_rpar));

   always_comb begin
      st_set              = '0;
      st_set[ST_PHY_PE]   = phy_err;
      st_set[ST_MAC_PE]   = mac_err;
      st_set[ST_CB_PE]    = cb_err;
      st_set[ST_CB_CANCL] = cb_err;
   end

   xpg_status #(.W(ST_W), .SET_PRIO(SET_PRIO)) u_status (
      .clk(clk), .rst_n(rst_n), .set(st_set), .clr(stat_clr), .q(status));

   a_r2_tx_odd: assert property (@(posedge clk) disable iff (!rst_n)
      ptx_vld_q |-> (^{ptx_data_q, ptx_par_q}) == 1'b1);
   a_r9_read_odd: assert property (@(posedge clk) disable iff (!rst_n)
      (^{reg_rdata, cb_rpar}) == 1'b1);
endmodule

// File: tb/tb_xpg_parity_guard.sv
`timescale 1ns/1ps
module tb_xpg_parity_guard;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic en_phy_par = 0, en_mac_par = 0, en_cb_par = 0;
   logic [7:0] ptx_data = 0; logic ptx_vld = 0;
   logic [7:0] ptx_data_q; logic ptx_par_q, ptx_vld_q;
   logic [7:0] prx_data = 0; logic prx_par = 0, prx_vld = 0, prx_in_frame = 0;
   logic prx_cv, prx_strip, prx_fmt_err; logic [7:0] lost_cnt;
   logic [7:0] mtx_data = 0; logic mtx_par = 0, mtx_vld = 0, mtx_ack = 0;
   logic mtx_abort, void_req;
   logic cb_wr = 0; logic [7:0] cb_wdata = 0; logic cb_wpar = 0;
   logic reg_wr; logic [7:0] reg_wdata; logic [7:0] reg_rdata = 0; logic cb_rpar;
   logic [3:0] stat_clr = 0; logic [3:0] status;

   xpg_parity_guard dut (
      .clk(clk), .rst_n(rst_n), .en_phy_par(en_phy_par), .en_mac_par(en_mac_par),
      .en_cb_par(en_cb_par), .ptx_data(ptx_data), .ptx_vld(ptx_vld),
      .ptx_data_q(ptx_data_q), .ptx_par_q(ptx_par_q), .ptx_vld_q(ptx_vld_q),
      .prx_data(prx_data), .prx_par(prx_par), .prx_vld(prx_vld),
      .prx_in_frame(prx_in_frame), .prx_cv(prx_cv), .prx_strip(prx_strip),
      .prx_fmt_err(prx_fmt_err), .lost_cnt(lost_cnt), .mtx_data(mtx_data),
      .mtx_par(mtx_par), .mtx_vld(mtx_vld), .mtx_ack(mtx_ack),
      .mtx_abort(mtx_abort), .void_req(void_req), .cb_wr(cb_wr),
      .cb_wdata(cb_wdata), .cb_wpar(cb_wpar), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cb_rpar(cb_rpar),
      .stat_clr(stat_clr), .status(status));

   int checks = 0, errors = 0;
   bit done = 0;

   // reference model state
   int e_ptx_d = 0, e_ptx_p = 1, e_ptx_v = 0;
   int e_cv = 0, e_strip = 0, e_fmt = 0, e_lost = 0;
   int e_abort = 0, e_void = 0, e_regwr = 0, e_regwd = 0;
   int e_stat = 0;

   function automatic bit even_ones(input logic [8:0] v);
      return ($countones(v) % 2) == 0;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         e_ptx_d = 0; e_ptx_p = 1; e_ptx_v = 0; e_cv = 0; e_strip = 0; e_fmt = 0;
         e_lost = 0; e_abort = 0; e_void = 0; e_regwr = 0; e_regwd = 0; e_stat = 0;
      end else begin
         bit pe, me, ce; int setv;
         pe = en_phy_par && prx_vld && even_ones({prx_data, prx_par});
         me = en_mac_par && mtx_vld && mtx_ack && even_ones({mtx_data, mtx_par});
         ce = en_cb_par && cb_wr && even_ones({cb_wdata, cb_wpar});
         e_ptx_d = ptx_data; e_ptx_v = ptx_vld;
         e_ptx_p = ($countones(ptx_data) % 2 == 0) ? 1 : 0;
         e_cv = pe; e_strip = pe && prx_in_frame; e_fmt = e_strip;
         if (e_strip && e_lost < 255) e_lost++;
         e_void = e_abort; e_abort = me;
         e_regwr = cb_wr && !ce; e_regwd = cb_wdata;
         setv = (pe ? 1 : 0) | (me ? 2 : 0) | (ce ? 12 : 0);
         e_stat = (e_stat & ~int'(stat_clr)) | setv;
      end
   end

   // compare on every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R2 ptx_data_q", ptx_data_q, e_ptx_d);
         chk("R2 ptx_par_q", ptx_par_q, e_ptx_p);
         chk("R2 ptx_vld_q", ptx_vld_q, e_ptx_v);
         chk("R3 prx_cv", prx_cv, e_cv);
         chk("R4 prx_strip", prx_strip, e_strip);
         chk("R4 prx_fmt_err", prx_fmt_err, e_fmt);
         chk("R4 lost_cnt", lost_cnt, e_lost);
         chk("R5 mtx_abort", mtx_abort, e_abort);
         chk("R6 void_req", void_req, e_void);
         chk("R7 reg_wr", reg_wr, e_regwr);
         if (e_regwr != 0) chk("R7 reg_wdata", reg_wdata, e_regwd);
         chk("R10 status", status, e_stat);
      end
   end

   task automatic drive(input int bad_pct, input bit frame);
      @(negedge clk);
      ptx_data = 8'($urandom); ptx_vld = 1'($urandom);
      prx_data = 8'($urandom); prx_vld = 1'($urandom); prx_in_frame = frame;
      prx_par = (($countones(prx_data) % 2 == 0) ^ ($urandom_range(99) < bad_pct)) ? 1 : 0;
      mtx_data = 8'($urandom); mtx_vld = 1'($urandom); mtx_ack = 1'($urandom);
      mtx_par = (($countones(mtx_data) % 2 == 0) ^ ($urandom_range(99) < bad_pct)) ? 1 : 0;
      cb_wr = 1'($urandom); cb_wdata = 8'($urandom);
      cb_wpar = (($countones(cb_wdata) % 2 == 0) ^ ($urandom_range(99) < bad_pct)) ? 1 : 0;
      reg_rdata = 8'($urandom);
      stat_clr = ($urandom_range(9) == 0) ? 4'($urandom) : 4'h0;
      #1;
      chk("R9 cb_rpar", cb_rpar, ($countones(reg_rdata) % 2 == 0) ? 1 : 0);
   endtask

   initial begin
      #200000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 status", status, 0); chk("R1 lost_cnt", lost_cnt, 0);
      chk("R1 pulses", {prx_cv, prx_strip, prx_fmt_err, mtx_abort, void_req, reg_wr, ptx_vld_q}, 0);
      rst_n = 1;
      // all checks enabled, mixed framing
      en_phy_par = 1; en_mac_par = 1; en_cb_par = 1;
      for (int i = 0; i < 400; i++) drive(30, i[3]);
      // all checks disabled: R3, R5, R8 no-effect cases
      en_phy_par = 0; en_mac_par = 0; en_cb_par = 0;
      stat_clr = 4'hF; @(negedge clk);
      for (int i = 0; i < 300; i++) drive(50, 1'b1);
      // R4 saturation: every received byte bad and inside a frame
      en_phy_par = 1;
      for (int i = 0; i < 600; i++) begin
         drive(100, 1'b1);
         prx_vld = 1;
      end
      @(negedge clk);
      chk("R4 lost_cnt saturated", lost_cnt, 255);
      // R10: set and clear in the same cycle keeps the bit
      en_mac_par = 1; en_cb_par = 1;
      for (int i = 0; i < 400; i++) begin
         drive(40, i[2]);
         stat_clr = 4'($urandom);
      end
      drive(0, 0);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule